// File: doc/BRIEF.md
# Receive Status Flag Controller

This block keeps the status flags of an asynchronous serial receiver. The flags are data-ready, overrun, noise and framing error. It also holds the receive data register. A receiver core reports each finished character with a one-cycle `char_done` pulse. With that pulse come the character byte, a stop-bit-good indication and a noise indication that covers every sampled bit of the character, the start and stop bits included.

The controller makes three decisions for each character. It can load the character into the data register and raise the flags that go with it. It can report an overrun and throw the character away. It can drop the character because a framing error is still pending. A bus reads the status word through `stat_rd` and the data register through `data_rd`.

- **Data-ready** clears on any data read.
- **Error flags** clear only through a two-step sequence. First a status read must observe the flag set. A data read that comes later then clears it.

Top module: `rx_status_ctrl`

## Requirements
- R1: After reset every flag is zero, the status word reads zero and the data register reads zero.
- R2: A character that completes while data-ready is clear and no framing error is pending is written to the data register. Data-ready (status bit 5) reads one in the cycle after the `char_done` pulse.
- R3: The noise flag (status bit 2) becomes set only in the same cycle as data-ready becomes set, for a loaded character that had `noise_hit` high. A loaded character without noise leaves the flag as it was.
- R4: The framing flag (status bit 1) becomes set in the same cycle as data-ready, for a loaded character whose `stop_ok` was low.
- R5: A character that completes while data-ready is set raises the overrun flag (status bit 3) and is discarded. The data register, noise flag and framing flag are left unchanged even when the stop bit was bad, so framing is never reported together with overrun.
- R6: A character that completes while the framing flag is set and data-ready is clear is discarded. The data register and every flag stay unchanged.
- R7: A data read clears data-ready, with or without an earlier status read.
- R8: An error flag (overrun, noise, framing) is cleared by a data read only if a status read observed that flag set after the previous data read. A data read without such a status read leaves the error flags unchanged.
- R9: A status read arms the clear only for the error flags set at the moment of that read. An error flag raised between the status read and the data read survives that data read.
- R10: Status bit 0, and every bit other than 5, 3, 2 and 1, always reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| char_done | input | 1 | One-cycle pulse: a character has finished |
| stop_ok | input | 1 | Stop bit of the finished character was valid |
| noise_hit | input | 1 | Noise seen on any bit of the finished character |
| rx_char | input | DATA_W | Finished character |
| stat_rd | input | 1 | Status word read strobe |
| data_rd | input | 1 | Data register read strobe |
| status | output | STAT_W | Status word |
| data_out | output | DATA_W | Data register |

## Verification
The bench builds the block with its defaults: 8-bit characters, an 8-bit status word and flag positions 5, 3, 2 and 1. At that size it can sweep every combination of three prior states (empty, full, framing pending) with every stop-bit and noise value. It predicts the status word and the data register from the requirements alone. Dedicated sequences check the arm-then-clear rule: a data read with no status read first, and a flag raised between the status read and the data read.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  typedef struct packed {
    logic ovr;
    logic nse;
    logic frm;
  } err_t;

  localparam int ERR_W = 3;

  function automatic logic [7:0] bit_mask(input int pos);
    logic [7:0] m;
    m = '0;
    m[pos] = 1'b1;
    return m;
  endfunction

  // assembles the status word from the flag state and the bit positions
  function automatic logic [7:0] pack_status(input logic rdy, input err_t e,
                                             input int p_rdy, input int p_ovr,
                                             input int p_nse, input int p_frm);
    logic [7:0] w;
    w = '0;
    if (rdy)   w = w | bit_mask(p_rdy);
    if (e.ovr) w = w | bit_mask(p_ovr);
    if (e.nse) w = w | bit_mask(p_nse);
    if (e.frm) w = w | bit_mask(p_frm);
    return w;
  endfunction
endpackage

// File: rtl/rxs_event_decode.sv
module rxs_event_decode (
  input  logic char_done,
  input  logic rdy_q,
  input  logic frm_q,
  output logic ev_load,
  output logic ev_ovr,
  output logic ev_drop
);
  // the three outcomes of a finished character are mutually exclusive
  always_comb begin
    ev_load = char_done && !rdy_q && !frm_q;
    ev_ovr  = char_done && rdy_q;
    ev_drop = char_done && !rdy_q && frm_q;
  end
endmodule

// File: rtl/rxs_clear_arm.sv
module rxs_clear_arm
  import rxs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic stat_rd,
  input  logic data_rd,
  input  err_t err_q,
  output err_t arm_q,
  output err_t clr
);
  err_t arm_d;

  always_comb begin
    clr = data_rd ? arm_q : err_t'('0);
    if (stat_rd)      arm_d = err_q;
    else if (data_rd) arm_d = '0;
    else              arm_d = arm_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) arm_q <= '0;
    else        arm_q <= arm_d;
  end
endmodule

// File: rtl/rxs_flag_bank.sv
module rxs_flag_bank
  import rxs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_load,
  input  logic              ev_ovr,
  input  logic              stop_ok,
  input  logic              noise_hit,
  input  logic [DATA_W-1:0] rx_char,
  input  logic              data_rd,
  input  err_t              clr,
  output logic              rdy_q,
  output err_t              err_q,
  output logic [DATA_W-1:0] data_q
);
  logic              rdy_d;
  err_t              err_d;
  logic [DATA_W-1:0] data_d;

  always_comb begin
    rdy_d     = (rdy_q && !data_rd) || ev_load;
    err_d.ovr = (err_q.ovr && !clr.ovr) || ev_ovr;
    err_d.nse = (err_q.nse && !clr.nse) || (ev_load && noise_hit);
    err_d.frm = (err_q.frm && !clr.frm) || (ev_load && !stop_ok);
    data_d    = ev_load ? rx_char : data_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy_q  <= 1'b0;
      err_q  <= '0;
      data_q <= '0;
    end else begin
      rdy_q  <= rdy_d;
      err_q  <= err_d;
      data_q <= data_d;
    end
  end
endmodule

// File: rtl/rx_status_ctrl.sv
module rx_status_ctrl
  import rxs_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int STAT_W  = 8,
  parameter int RDY_POS = 5,
  parameter int OVR_POS = 3,
  parameter int NSE_POS = 2,
  parameter int FRM_POS = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              char_done,
  input  logic              stop_ok,
  input  logic              noise_hit,
  input  logic [DATA_W-1:0] rx_char,
  input  logic              stat_rd,
  input  logic              data_rd,
  output logic [STAT_W-1:0] status,
  output logic [DATA_W-1:0] data_out
);
  localparam int PACK_W = 8;

  logic ev_load, ev_ovr, ev_drop;
  logic rdy_q;
  err_t err_q, arm_q, clr;
  logic [DATA_W-1:0] data_q;
  logic [PACK_W-1:0] packed_w;

  rxs_event_decode u_dec (
    .char_done(char_done), .rdy_q(rdy_q), .frm_q(err_q.frm),
    .ev_load(ev_load), .ev_ovr(ev_ovr), .ev_drop(ev_drop)
  );

  rxs_clear_arm u_arm (
    .clk(clk), .rst_n(rst_n), .stat_rd(stat_rd), .data_rd(data_rd),
    .err_q(err_q), .arm_q(arm_q), .clr(clr)
  );

  rxs_flag_bank #(.DATA_W(DATA_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .ev_load(ev_load), .ev_ovr(ev_ovr),
    .stop_ok(stop_ok), .noise_hit(noise_hit), .rx_char(rx_char),
    .data_rd(data_rd), .clr(clr), .rdy_q(rdy_q), .err_q(err_q),
    .data_q(data_q)
  );

  assign packed_w = pack_status(rdy_q, err_q, RDY_POS, OVR_POS, NSE_POS, FRM_POS);

  generate
    if (STAT_W >= PACK_W) begin : g_wide
      assign status = {{(STAT_W-PACK_W){1'b0}}, packed_w};
    end else begin : g_narrow
      assign status = packed_w[STAT_W-1:0];
    end
  endgenerate

  assign data_out = data_q;
endmodule

// File: rtl/rxs_chk.sv
module rxs_chk
  import rxs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              char_done,
  input logic              stop_ok,
  input logic              data_rd,
  input logic              stat_rd,
  input logic              rdy_q,
  input err_t              err_q,
  input err_t              arm_q,
  input logic              ev_drop,
  input logic [DATA_W-1:0] data_q
);
  // R2
  load_sets_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    char_done && !rdy_q && !err_q.frm |=> rdy_q);
  // R3
  nse_with_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q.nse) |-> $rose(rdy_q));
  // R4
  frm_with_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q.frm) |-> $rose(rdy_q));
  // R5
  ovr_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    char_done && rdy_q |=> err_q.ovr && $stable(data_q));
  // R5
  ovr_not_frm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q.ovr) |-> !$rose(err_q.frm));
  // R6
  drop_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_drop |=> $stable(data_q) && !rdy_q);
  // R7
  rd_clears_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_rd && rdy_q |=> !rdy_q);
  // R8
  nse_clear_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_q.nse) |-> $past(data_rd) && $past(arm_q.nse));
  // R8
  frm_clear_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_q.frm) |-> $past(data_rd) && $past(arm_q.frm));
  // R9
  ovr_clear_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_q.ovr) |-> $past(data_rd) && $past(arm_q.ovr));
endmodule

bind rx_status_ctrl rxs_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .char_done(char_done), .stop_ok(stop_ok),
  .data_rd(data_rd), .stat_rd(stat_rd), .rdy_q(rdy_q), .err_q(err_q),
  .arm_q(arm_q), .ev_drop(ev_drop), .data_q(data_q)
);

// File: tb/rx_status_ctrl_bench.sv
module rx_status_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int SW = 8;
  localparam logic [7:0] M_RDY = 8'h20;
  localparam logic [7:0] M_OVR = 8'h08;
  localparam logic [7:0] M_NSE = 8'h04;
  localparam logic [7:0] M_FRM = 8'h02;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic char_done = 1'b0, stop_ok = 1'b1, noise_hit = 1'b0;
  logic stat_rd = 1'b0, data_rd = 1'b0;
  logic [DW-1:0] rx_char = '0;
  logic [SW-1:0] status;
  logic [DW-1:0] data_out;

  int compared = 0;
  int mismatched = 0;
  logic [7:0] last_stat;

  // bench model of the flags
  logic m_rdy, m_ovr, m_nse, m_frm;
  logic [DW-1:0] m_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_status_ctrl u_rx_status_ctrl (
    .clk(clk), .rst_n(rst_n), .char_done(char_done), .stop_ok(stop_ok),
    .noise_hit(noise_hit), .rx_char(rx_char), .stat_rd(stat_rd),
    .data_rd(data_rd), .status(status), .data_out(data_out)
  );

  function automatic logic [7:0] model_word();
    return (m_rdy ? M_RDY : 8'h00) | (m_ovr ? M_OVR : 8'h00) |
           (m_nse ? M_NSE : 8'h00) | (m_frm ? M_FRM : 8'h00);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [DW-1:0] c, input logic st, input logic nz);
    @(negedge clk);
    char_done = 1'b1; rx_char = c; stop_ok = st; noise_hit = nz;
    @(negedge clk);
    char_done = 1'b0; stop_ok = 1'b1; noise_hit = 1'b0;
    if (!m_rdy && !m_frm) begin
      m_rdy = 1'b1; m_data = c; m_nse = m_nse | nz; m_frm = !st;
    end else if (m_rdy) begin
      m_ovr = 1'b1;
    end
  endtask

  logic a_ovr, a_nse, a_frm;

  task automatic read_stat();
    @(negedge clk);
    stat_rd = 1'b1;
    last_stat = status;
    a_ovr = m_ovr; a_nse = m_nse; a_frm = m_frm;
    @(negedge clk);
    stat_rd = 1'b0;
  endtask

  task automatic read_data(input logic armed);
    @(negedge clk);
    data_rd = 1'b1;
    @(negedge clk);
    data_rd = 1'b0;
    m_rdy = 1'b0;
    if (armed) begin
      if (a_ovr) m_ovr = 1'b0;
      if (a_nse) m_nse = 1'b0;
      if (a_frm) m_frm = 1'b0;
      a_ovr = 0; a_nse = 0; a_frm = 0;
    end
  endtask

  task automatic drain();
    read_stat();
    read_data(1'b1);
    check("R8 drain", status, 8'h00);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    mismatched++;
    compared++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    m_rdy = 0; m_ovr = 0; m_nse = 0; m_frm = 0; m_data = '0;
    a_ovr = 0; a_nse = 0; a_frm = 0;
    repeat (3) @(negedge clk);
    check("R1 status", status, 8'h00);
    check("R1 data", data_out, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after", status, 8'h00);

    // sweep: prior state x stop bit x noise
    for (int pre = 0; pre < 3; pre++) begin
      for (int st = 0; st < 2; st++) begin
        for (int nz = 0; nz < 2; nz++) begin
          logic [DW-1:0] pat;
          pat = DW'(8'h31 + pre*16 + st*4 + nz);
          if (pre == 1) send(8'hA5, 1'b1, 1'b0);
          if (pre == 2) begin
            send(8'h5A, 1'b0, 1'b0);
            read_data(1'b0);              // R7: rdy clears, frm stays
            check("R7 rdy cleared, frm held", status, M_FRM);
          end
          send(pat, st[0], nz[0]);
          if (pre == 0)      check("R2/R3/R4 load", status, model_word());
          else if (pre == 1) check("R5 overrun", status, model_word());
          else               check("R6 dropped", status, model_word());
          check("R2/R5/R6 data", data_out, m_data);
          check("R10 bit0", status[0], 1'b0);
          drain();
        end
      end
    end

    // R8: data read without status read keeps error flags
    send(8'h11, 1'b1, 1'b1);
    read_data(1'b0);
    check("R8 nse kept", status, M_NSE);
    send(8'h22, 1'b1, 1'b0);              // R3: no new noise, nse stays
    check("R3 nse sticky", status, M_RDY | M_NSE);
    drain();

    // R9: flag raised after status read survives data read
    send(8'h33, 1'b1, 1'b1);
    read_stat();
    check("R10 stat view", last_stat, M_RDY | M_NSE);
    send(8'h44, 1'b0, 1'b0);              // overrun, frm not set (R5)
    check("R5 no frm on overrun", status, M_RDY | M_NSE | M_OVR);
    read_data(1'b1);
    check("R9 ovr survives", status, M_OVR);
    check("R9 model", status, model_word());
    read_data(1'b0);
    check("R8 ovr held", status, M_OVR);
    drain();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule